// File: doc/BRIEF.md
# Serial Command Loader with Held Actuator Outputs

This block receives a command one bit at a time on a single serial line, paced by a slow command clock that is separate from the system clock, and presents each finished command as a set of parallel actuator drives. A chain of two-phase shift stages lines the received bits up side by side. The newest bit needs no stage because it is taken straight from the serial line, so a command of `STAGES+1` bits needs only `STAGES` stages.

A separate bank of holding bits copies the lined-up word whenever the load input is sampled high. The bank then keeps its value while the next command shifts in, so the actuators never see a half-shifted command. Each held bit drives one target in true form and in complemented form. A 1 means the target is active (open) and a 0 means it is inactive (closed).

The command clock, serial data and load inputs are all sampled on the system clock. Each half of a shift stage behaves like a level-sensitive latch, built as an enabled register.

Top module: `cmd_loader`

## Requirements
- R1: While `rst_ni` is low, every bit of `act_o` is 0 and every bit of `act_n_o` is 1. Both hold these values until the first load after reset.
- R2: `act_n_o` is the bitwise complement of `act_o` at all times.
- R3: In each stage, the first half follows its input at every system clock edge where `sclk_i` is 1 and holds while `sclk_i` is 0. The data therefore moves exactly one stage per full `sclk_i` period (a high phase followed by a low phase).
- R4: The parallel word is ordered as follows. Bit 0 is the live `sdata_i`, and bit k (1..STAGES) is the output of shift stage k. After bits d0, d1, d2 are shifted in over three `sclk_i` periods, with d3 then present on `sdata_i`, a load gives `act_o` = {d0,d1,d2,d3} (bit 3 down to bit 0). The oldest bit is therefore on the highest index.
- R5: A system clock edge with `load_i` high copies the parallel word into the holding bank. `act_o` shows that word from that edge on.
- R6: While `load_i` is low, `act_o` keeps its value no matter how `sclk_i` or `sdata_i` change.
- R7: When `load_i` is held high for several cycles, the bank reloads at every edge. Each change on `sdata_i` therefore shows on `act_o[0]` one edge later.
- R8: In each stage, the second half holds while `sclk_i` is 1. A load during a high phase therefore sees the old contents of stages 1..STAGES, even when `sdata_i` changes during that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Command clock, sampled on clk_i |
| sdata_i | input | 1 | Serial command bit |
| load_i | input | 1 | Copy the parallel word into the holding bank |
| act_o | output | STAGES+1 | Held command, true form |
| act_n_o | output | STAGES+1 | Held command, complemented form |

## Verification
The assertions assume that `sclk_i`, `sdata_i` and `load_i` are settled at every system clock edge. They also assume that the command clock stays in each phase long enough for a latch half to take its value. The stimulus changes every input on the falling system edge only. It holds each command clock phase for two system cycles and keeps `sdata_i` steady through the high phase of a normal shift. Only the directed R8 case changes `sdata_i` during a high phase, to show that the stage outputs stay shielded.

// File: rtl/cmd_loader_pkg.sv
package cmd_loader_pkg;
  localparam int unsigned DEF_STAGES = 3;

  function automatic int unsigned word_width(input int unsigned stages);
    return stages + 1;
  endfunction
endpackage

// File: rtl/cmd_shift_stage.sv
module cmd_shift_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic d_i,
  output logic q_o
);
  logic front_q, back_q;

  // front half transparent while sclk high, back half while sclk low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      front_q <= 1'b0;
      back_q  <= 1'b0;
    end else if (sclk_i) begin
      front_q <= d_i;
    end else begin
      back_q  <= front_q;
    end
  end

  assign q_o = back_q;

  p_front_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_i |=> $stable(front_q));
  p_back_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_i |=> $stable(q_o));
endmodule

// File: rtl/cmd_hold_bank.sv
module cmd_hold_bank #(
  parameter int unsigned WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [WIDTH-1:0] par_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] qn_o
);
  logic [WIDTH-1:0] hold_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     hold_q[b] <= 1'b0;
      else if (load_i) hold_q[b] <= par_i[b];
    end
    assign q_o[b]  = hold_q[b];
    assign qn_o[b] = ~hold_q[b];
  end

  p_load_copy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> q_o == $past(par_i));
  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(q_o));
endmodule

// File: rtl/cmd_loader.sv
module cmd_loader
  import cmd_loader_pkg::*;
#(
  parameter int unsigned STAGES = DEF_STAGES,
  localparam int unsigned W = STAGES + 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sclk_i,
  input  logic         sdata_i,
  input  logic         load_i,
  output logic [W-1:0] act_o,
  output logic [W-1:0] act_n_o
);
  logic [W-1:0] par;

  // bit 0 is the live serial line, bit k the output of stage k
  assign par[0] = sdata_i;

  for (genvar k = 1; k <= STAGES; k++) begin : g_stage
    cmd_shift_stage u_stage (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .sclk_i (sclk_i),
      .d_i    (par[k-1]),
      .q_o    (par[k])
    );
  end

  cmd_hold_bank #(.WIDTH(W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_i),
    .par_i  (par),
    .q_o    (act_o),
    .qn_o   (act_n_o)
  );

  p_compl_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_n_o == ~act_o);
  p_live_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> act_o[0] == $past(sdata_i));
endmodule

// File: tb/cmd_loader_bench.sv
`timescale 1ns/1ps
module cmd_loader_bench;
  localparam int unsigned STAGES = 3;
  localparam int unsigned W = STAGES + 1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, load = 1'b0;
  logic [W-1:0] act, act_n;
  logic [STAGES:1] st = '0;
  logic [W-1:0] held = '0;
  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cmd_loader #(.STAGES(STAGES)) u_cmd_loader (
    .clk_i(clk), .rst_ni(rst_ni), .sclk_i(sclk), .sdata_i(sdata),
    .load_i(load), .act_o(act), .act_n_o(act_n)
  );

  function automatic logic [W-1:0] par_word(input logic [STAGES:1] s, input logic live);
    return {s, live};
  endfunction

  task automatic check(input string req, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp || act_n !== ~exp) begin
      n_bad++;
      $display("FAIL %s act=%b act_n=%b expected act=%b act_n=%b", req, act, act_n, exp, ~exp);
    end
  endtask

  task automatic shift_bit(input logic b);
    sdata = b; sclk = 1'b1;
    repeat (2) @(negedge clk);
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    st = {st[STAGES-1:1], b};
  endtask

  task automatic do_load(input string req);
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    held = par_word(st, sdata);
    check(req, held);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_vec++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check("R1", '0);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1", '0);

    // R4: d0..d2 shifted, d3 live
    shift_bit(1'b1); shift_bit(1'b0); shift_bit(1'b0);
    sdata = 1'b1;
    @(negedge clk);
    do_load("R4");
    check("R4", 4'b1001);

    // R6: shifting without load leaves outputs alone
    shift_bit(1'b0); shift_bit(1'b1); sdata = 1'b0;
    @(negedge clk);
    check("R6", held);

    // R8: load in mid high phase sees old stage contents
    sclk = 1'b1; sdata = 1'b1;
    @(negedge clk);
    sdata = 1'b0;
    @(negedge clk);
    sdata = 1'b1;
    do_load("R8");
    sclk = 1'b0;
    repeat (2) @(negedge clk);
    st = {st[STAGES-1:1], 1'b1};
    do_load("R3");

    // R7: load held high, live bit reloaded each edge
    load = 1'b1;
    for (int i = 0; i < 4; i++) begin
      sdata = i[0];
      @(negedge clk);
      held = par_word(st, sdata);
      check("R7", held);
    end
    load = 1'b0;

    // random mix
    for (int it = 0; it < 300; it++) begin
      int nsh = $urandom_range(0, 4);
      for (int j = 0; j < nsh; j++) shift_bit(1'($urandom));
      sdata = 1'($urandom);
      @(negedge clk);
      if ($urandom_range(0, 3) != 0) do_load("R5");
      else check("R6", held);
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule